// File: doc/BRIEF.md
# Serial Receiver Interrupt and Frame-Sync Source Selector

This block produces the receive interrupt request of a buffered serial port receiver. A 2-bit mode input picks one of four event sources. They are a rising receive-ready flag, block or frame boundary strobes in multichannel selection mode, a detected receive frame-sync pulse, and a rising frame-sync error flag. Each qualifying event gives exactly one interrupt pulse, one CPU clock wide.

The block also chooses where the receiver's internal frame sync comes from. The sources are the external pin with programmable polarity, the sample-rate generator, or the transmit frame sync when loopback or clock-stop operation is selected. In clock-stop operation the receive clock is also taken from the transmit clock. The block drives the pin output value and the pin output enable. The frame-sync interrupt path runs through a synchronizer into the CPU clock domain. That path keeps working while the receiver is held in reset.

Top module: `rx_irq_fsync_top`

## Requirements
- R1: With irq_mode_i = 2'b00, a 0-to-1 change of rx_ready_i sampled at clock edge n drives irq_o high for the cycle after edge n.
- R2: A flag that stays high gives no further interrupt; rx_ready_i and sync_err_i raise irq_o only on their rising edge.
- R3: With irq_mode_i = 2'b01 and mcsel_en_i high, a cycle with blk_end_i or frame_end_i high (or both) drives irq_o high for exactly the next cycle.
- R4: With irq_mode_i = 2'b01 and mcsel_en_i low, irq_o stays low whatever the strobes do.
- R5: With irq_mode_i = 2'b10, a 0-to-1 change of fs_int_o sampled at edge n drives irq_o high for the cycle after edge n+2, from a two-flop synchronizer and an edge detector. This also holds while rx_rst_i is high.
- R6: With irq_mode_i = 2'b11, a 0-to-1 change of sync_err_i sampled at edge n drives irq_o high for the cycle after edge n.
- R7: While rx_rst_i is high, modes 2'b00, 2'b01 and 2'b11 produce no interrupt.
- R8: With loopback_i and clk_stop_i low, fs_int_o equals fs_pin_i when fs_int_sel_i = 0 and fs_pol_i = 0. It equals the inverse of fs_pin_i when fs_int_sel_i = 0 and fs_pol_i = 1 (active low). It equals srg_fs_i when fs_int_sel_i = 1.
- R9: When loopback_i or clk_stop_i is high, fs_int_o equals tx_fs_i. rx_clk_o equals tx_clk_i when clk_stop_i is high and rx_clk_ext_i otherwise.
- R10: fs_pin_oe_o is high only when fs_int_sel_i = 1 and srg_sync_ext_i = 0. fs_pin_o is fs_int_o, inverted when fs_pol_i = 1.
- R11: A change of irq_mode_i applies from the next edge. Edge history is tracked in every mode, so a switch into a flag mode while the flag is already high gives no interrupt.
- R12: During and right after reset, irq_o is low and all edge history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_mode_i | input | 2 | Interrupt source select |
| fs_int_sel_i | input | 1 | 1: sync from sample-rate generator, 0: from pin |
| srg_sync_ext_i | input | 1 | Generator locked to external sync; pin stays input |
| loopback_i | input | 1 | Digital loopback enable |
| clk_stop_i | input | 1 | Clock-stop operation enable |
| fs_pol_i | input | 1 | 1: pin frame sync active low |
| fs_pin_i | input | 1 | Frame-sync pin input value |
| srg_fs_i | input | 1 | Sample-rate generator frame sync |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_clk_i | input | 1 | Transmit clock |
| rx_clk_ext_i | input | 1 | Receive clock from pin |
| rx_rst_i | input | 1 | Receiver held in reset |
| rx_ready_i | input | 1 | Receive-ready flag |
| sync_err_i | input | 1 | Receive frame-sync error flag |
| mcsel_en_i | input | 1 | Multichannel selection mode active |
| blk_end_i | input | 1 | Strobe: 16-channel block boundary crossed |
| frame_end_i | input | 1 | Strobe: end of frame |
| irq_o | output | 1 | Receive interrupt pulse |
| fs_int_o | output | 1 | Selected internal receive frame sync, active high |
| fs_pin_o | output | 1 | Frame-sync pin output value |
| fs_pin_oe_o | output | 1 | Frame-sync pin output enable |
| rx_clk_o | output | 1 | Selected receive clock |

## Verification
A stuck or uncleared edge-history register shows up at irq_o as a missing or repeated pulse. For the flag modes it appears one cycle after the flag rises. For the frame-sync mode it appears three cycles after. A wrong synchronizer depth shifts the frame-sync interrupt by a whole cycle, which the per-cycle comparison sees at once. Source-select faults appear on fs_int_o, fs_pin_o or fs_pin_oe_o in the same cycle as the configuration change.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  typedef enum logic [1:0] {
    IRQ_RDY = 2'b00,
    IRQ_MCH = 2'b01,
    IRQ_FS  = 2'b10,
    IRQ_ERR = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/rx_edge_det.sv
module rx_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end
  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  rx_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_q[STAGES-1]),
    .rise_o (rise_o)
  );
endmodule

// File: rtl/rx_fsync_sel.sv
module rx_fsync_sel (
  input  logic fs_int_sel_i,
  input  logic srg_sync_ext_i,
  input  logic loopback_i,
  input  logic clk_stop_i,
  input  logic fs_pol_i,
  input  logic fs_pin_i,
  input  logic srg_fs_i,
  input  logic tx_fs_i,
  input  logic tx_clk_i,
  input  logic rx_clk_ext_i,
  output logic fs_int_o,
  output logic fs_pin_o,
  output logic fs_pin_oe_o,
  output logic rx_clk_o
);
  logic tie_tx;
  assign tie_tx = loopback_i | clk_stop_i;

  always_comb begin
    if (tie_tx)            fs_int_o = tx_fs_i;
    else if (fs_int_sel_i) fs_int_o = srg_fs_i;
    else                   fs_int_o = fs_pin_i ^ fs_pol_i;
  end

  assign fs_pin_o    = fs_int_o ^ fs_pol_i;
  assign fs_pin_oe_o = fs_int_sel_i & ~srg_sync_ext_i;
  assign rx_clk_o    = clk_stop_i ? tx_clk_i : rx_clk_ext_i;
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import rx_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       rx_rst_i,
  input  logic       rx_ready_i,
  input  logic       sync_err_i,
  input  logic       mcsel_en_i,
  input  logic       blk_end_i,
  input  logic       frame_end_i,
  input  logic       fs_rise_i,
  output logic       irq_o
);
  irq_mode_e mode;
  logic rdy_rise, err_rise, ev, irq_q;

  assign mode = irq_mode_e'(mode_i);

  // history tracked in every mode so a mode switch cannot fake an edge
  rx_edge_det u_rdy (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_ready_i), .rise_o(rdy_rise));
  rx_edge_det u_err (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_err_i), .rise_o(err_rise));

  always_comb begin
    unique case (mode)
      IRQ_RDY: ev = ~rx_rst_i & rdy_rise;
      IRQ_MCH: ev = ~rx_rst_i & mcsel_en_i & (blk_end_i | frame_end_i);
      IRQ_FS:  ev = fs_rise_i;
      IRQ_ERR: ev = ~rx_rst_i & err_rise;
      default: ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ev;
  end
  assign irq_o = irq_q;

  // R1
  rdy_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IRQ_RDY && !rx_rst_i && rdy_rise) |=> irq_o);
  // R4
  mch_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IRQ_MCH && !mcsel_en_i) |=> !irq_o);
  // R5
  fs_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IRQ_FS && fs_rise_i) |=> irq_o);
  // R7
  rx_rst_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rst_i && mode_i != IRQ_FS) |=> !irq_o);
endmodule

// File: rtl/rx_irq_fsync_top.sv
module rx_irq_fsync_top #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] irq_mode_i,
  input  logic       fs_int_sel_i,
  input  logic       srg_sync_ext_i,
  input  logic       loopback_i,
  input  logic       clk_stop_i,
  input  logic       fs_pol_i,
  input  logic       fs_pin_i,
  input  logic       srg_fs_i,
  input  logic       tx_fs_i,
  input  logic       tx_clk_i,
  input  logic       rx_clk_ext_i,
  input  logic       rx_rst_i,
  input  logic       rx_ready_i,
  input  logic       sync_err_i,
  input  logic       mcsel_en_i,
  input  logic       blk_end_i,
  input  logic       frame_end_i,
  output logic       irq_o,
  output logic       fs_int_o,
  output logic       fs_pin_o,
  output logic       fs_pin_oe_o,
  output logic       rx_clk_o
);
  logic fs_int, fs_rise;

  rx_fsync_sel u_sel (
    .fs_int_sel_i   (fs_int_sel_i),
    .srg_sync_ext_i (srg_sync_ext_i),
    .loopback_i     (loopback_i),
    .clk_stop_i     (clk_stop_i),
    .fs_pol_i       (fs_pol_i),
    .fs_pin_i       (fs_pin_i),
    .srg_fs_i       (srg_fs_i),
    .tx_fs_i        (tx_fs_i),
    .tx_clk_i       (tx_clk_i),
    .rx_clk_ext_i   (rx_clk_ext_i),
    .fs_int_o       (fs_int),
    .fs_pin_o       (fs_pin_o),
    .fs_pin_oe_o    (fs_pin_oe_o),
    .rx_clk_o       (rx_clk_o)
  );
  assign fs_int_o = fs_int;

  // receiver reset deliberately not applied: frame-sync interrupt must run during it
  rx_sync_edge #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (fs_int),
    .rise_o (fs_rise)
  );

  rx_irq_gen u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (irq_mode_i),
    .rx_rst_i    (rx_rst_i),
    .rx_ready_i  (rx_ready_i),
    .sync_err_i  (sync_err_i),
    .mcsel_en_i  (mcsel_en_i),
    .blk_end_i   (blk_end_i),
    .frame_end_i (frame_end_i),
    .fs_rise_i   (fs_rise),
    .irq_o       (irq_o)
  );

  // R9
  tx_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loopback_i || clk_stop_i) |-> (fs_int_o == tx_fs_i));
  // R10
  pin_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srg_sync_ext_i || !fs_int_sel_i) |-> !fs_pin_oe_o);
endmodule

// File: tb/rx_irq_fsync_top_tb_top.sv
module rx_irq_fsync_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic isel = 0, sext = 0, lb = 0, cs = 0, pol = 0, pin = 0, srg = 0, txfs = 0;
  logic txclk = 0, rxclk = 0, rxrst = 0, rdy = 0, err = 0, mcs = 0, blk = 0, fend = 0;
  logic irq, fs_int, fs_pin, fs_oe, rx_clk;

  int checks = 0, errors = 0, cyc = 0;
  int pend[$];
  logic prev_rdy = 0, prev_err = 0, prev_fs = 0, exp_irq = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_irq_fsync_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_mode_i(mode), .fs_int_sel_i(isel),
    .srg_sync_ext_i(sext), .loopback_i(lb), .clk_stop_i(cs), .fs_pol_i(pol),
    .fs_pin_i(pin), .srg_fs_i(srg), .tx_fs_i(txfs), .tx_clk_i(txclk),
    .rx_clk_ext_i(rxclk), .rx_rst_i(rxrst), .rx_ready_i(rdy), .sync_err_i(err),
    .mcsel_en_i(mcs), .blk_end_i(blk), .frame_end_i(fend), .irq_o(irq),
    .fs_int_o(fs_int), .fs_pin_o(fs_pin), .fs_pin_oe_o(fs_oe), .rx_clk_o(rx_clk)
  );

  function automatic logic m_fs();
    if (lb || cs) return txfs;
    if (isel) return srg;
    return pol ? ~pin : pin;
  endfunction

  // behavioural reference: events scheduled by cycle number
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rdy = 0; prev_err = 0; prev_fs = 0; exp_irq = 0; pend.delete();
    end else begin
      logic ev, fs_due;
      fs_due = 0;
      foreach (pend[k]) if (pend[k] == cyc) fs_due = 1;
      case (mode)
        2'b00: ev = !rxrst && rdy && !prev_rdy;
        2'b01: ev = !rxrst && mcs && (blk || fend);
        2'b10: ev = fs_due;
        default: ev = !rxrst && err && !prev_err;
      endcase
      exp_irq = ev;
      if (m_fs() && !prev_fs) pend.push_back(cyc + 2);
      while (pend.size() > 0 && pend[0] <= cyc) void'(pend.pop_front());
      prev_rdy = rdy; prev_err = err; prev_fs = m_fs();
      cyc++;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic efs;
    efs = m_fs();
    if (!rst_n) chk("R12", irq, 1'b0, "irq in reset");
    else begin
      chk(mode == 2'b10 ? "R5" : (mode == 2'b01 ? "R3" : "R1"), irq, exp_irq, "irq_o");
      chk((lb || cs) ? "R9" : "R8", fs_int, efs, "fs_int_o");
      chk("R10", fs_pin, pol ? ~efs : efs, "fs_pin_o");
      chk("R10", fs_oe, isel && !sext, "fs_pin_oe_o");
      chk("R9", rx_clk, cs ? txclk : rxclk, "rx_clk_o");
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_fs(int width, int gap);
    pin = ~pol; tick(width); pin = pol; tick(gap);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rdy = 1; // R12: flag high across reset release
    tick(3);
    rst_n = 1;
    tick(3); // R1: flag high at release counts as rise from cleared history
    rdy = 0; tick(2);
    // R1 / R2: rising edges and a held flag
    repeat (3) begin rdy = 1; tick(5); rdy = 0; tick(2); end
    // R7
    rxrst = 1; rdy = 1; tick(3); rdy = 0; tick(1); rxrst = 0; tick(2);
    // R3 / R4
    mode = 2'b01; blk = 1; tick(1); blk = 0; tick(2);
    mcs = 1; blk = 1; tick(1); blk = 0; fend = 1; tick(1); blk = 1; tick(1);
    blk = 0; fend = 0; tick(3);
    rxrst = 1; blk = 1; tick(1); blk = 0; rxrst = 0; mcs = 0; tick(2);
    // R6
    mode = 2'b11; err = 1; tick(4); err = 0; tick(1); err = 1; tick(1); err = 0; tick(3);
    // R11: switch into flag mode with flag already high
    rdy = 1; tick(3); mode = 2'b00; tick(4); rdy = 0; tick(1); rdy = 1; tick(2); rdy = 0;
    err = 1; tick(2); mode = 2'b11; tick(3); err = 0; tick(2);
    // R5 / R8: pin source, both polarities, and during receiver reset
    mode = 2'b10;
    repeat (2) pulse_fs(1, 4);
    pulse_fs(3, 5);
    pol = 1; pin = 1; tick(2);
    repeat (2) pulse_fs(2, 4);
    rxrst = 1; repeat (2) pulse_fs(1, 4); rxrst = 0;
    pol = 0; pin = 0; tick(2);
    // R8 / R10: generator source, pin direction
    isel = 1; tick(1); srg = 1; tick(2); srg = 0; tick(4);
    sext = 1; srg = 1; tick(2); srg = 0; tick(4); sext = 0;
    pol = 1; srg = 1; tick(2); srg = 0; tick(4); pol = 0;
    // R9: loopback and clock stop
    lb = 1; txfs = 1; tick(2); txfs = 0; tick(4); lb = 0;
    cs = 1; txclk = 1; rxclk = 0; txfs = 1; tick(2);
    txclk = 0; rxclk = 1; txfs = 0; tick(4); cs = 0;
    isel = 0; tick(2);
    // R11: fs history kept across a mode change
    mode = 2'b00; pulse_fs(1, 1); mode = 2'b10; tick(5);
    mode = 2'b00; tick(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule